// File: doc/BRIEF.md
# Time Base Interval Timer

A free-running prescaler counter that raises a periodic interrupt request at one of eight power-of-two divisions of its input clock. The counter advances on every clock, or only on cycles where a slow-clock enable is high, as chosen by software. A tap-select code names the divider stage whose rising transition sets a request flag.

Software reaches the block through a byte-wide register port: write enable, address, write data and a combinational read-data output. A mode register holds the source select and tap code. A write of any value to a clear register zeroes the counter. An interrupt control register holds a two-bit priority level, an enable bit and the request flag. The interrupt output is a level that stays high while the flag and enable are both set. Priority arbitration happens outside the block.

Top module: `tbt_top`

## Requirements
- R1: After reset the counter is 0, every register reads 0x00 and irq_o is 0.
- R2: The mode register at 0x3F6A stores the source select in bit 0 and the 3-bit tap code in bits 6:4, both taken from a single write. Its other bits read 0.
- R3: Tap codes 0..7 select division by 2^7, 2^8, 2^9, 2^10, 2^13, 2^14, 2^15 and 2^16. For a division 2^n the flag sets when counter bit n-1 rises: 2^(n-1) advances after a clear, then every 2^n advances.
- R4: A write of any data to the clear register at 0x3FF0-independent address 0x3F6B zeroes the counter. No advance and no flag set happen in that cycle. The clear register reads 0.
- R5: With source bit 0 the counter advances on every clock. With source bit 1 it advances only on cycles where slow_en_i is 1.
- R6: The control register at 0x3FF0 holds the level in bits 7:6, the enable in bit 1 and the request flag in bit 0. A write loads all three, so writing 0 in bit 0 clears the flag. Bits 5:2 read 0.
- R7: When the flag is set by hardware in the same cycle that software writes 0 to bit 0, the flag ends up 1.
- R8: irq_o is 1 exactly when both the flag and the enable are 1. The level has no effect on it.
- R9: rdata_o follows addr_i combinationally. Any address other than the three registers reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Register write data |
| slow_en_i | input | 1 | Slow-clock enable for source 1 |
| rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Register reads are due in the same cycle, so the bench samples rdata_o one step after it changes addr_i. A write driven at a falling edge takes effect at the next rising edge. Its result is sampled at the following falling edge. The flag is due at the rising edge that makes the 2^(n-1)-th advance after the clearing edge, so the bench counts falling edges from the clear's edge and compares that count with the number computed from the tap table. In slow-source runs it counts only the enables it drove before each edge.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int REG_W     = 8;
  localparam int TAP_CODES = 8;
  localparam int TAP_W     = $clog2(TAP_CODES);

  localparam int MODE_SRC_BIT = 0;
  localparam int MODE_TAP_LSB = 4;
  localparam int ICR_FLAG_BIT = 0;
  localparam int ICR_EN_BIT   = 1;
  localparam int ICR_LVL_LSB  = 6;

  // counter bit whose rising edge marks the period of a tap code
  function automatic int tap_bit(input logic [TAP_W-1:0] code);
    return (code < TAP_W'(4)) ? int'(code) + 6 : int'(code) + 8;
  endfunction
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler
  import tbt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic                 clr_i,
  input  logic [TAP_W-1:0]     tap_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 rise_o
);
  logic [CNT_W-1:0]     cnt_q;
  logic [TAP_CODES-1:0] edge_vec;

  // edge_vec[g]: next advance takes the tapped bit from 0 to 1
  for (genvar g = 0; g < TAP_CODES; g++) begin : g_tap
    localparam int B = tap_bit(TAP_W'(g));
    assign edge_vec[g] = (&cnt_q[B-1:0]) & ~cnt_q[B];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign rise_o = adv_i & ~clr_i & edge_vec[tap_i];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tbt_regs.sv
module tbt_regs
  import tbt_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h3F6A,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'h3F6B,
  parameter logic [ADDR_W-1:0] ICR_ADDR  = 16'h3FF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              set_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              src_o,
  output logic [TAP_W-1:0]  tap_o,
  output logic              clr_o,
  output logic              flag_o,
  output logic              en_o
);
  logic             mode_wr, icr_wr;
  logic             src_q, en_q, flag_q;
  logic [TAP_W-1:0] tap_q;
  logic [1:0]       lvl_q;
  logic             unused_wdata;

  assign mode_wr      = wr_en_i && (addr_i == MODE_ADDR);
  assign icr_wr       = wr_en_i && (addr_i == ICR_ADDR);
  assign clr_o        = wr_en_i && (addr_i == CLR_ADDR);
  assign unused_wdata = ^wdata_i[3:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      tap_q <= '0;
    end else if (mode_wr) begin
      src_q <= wdata_i[MODE_SRC_BIT];
      tap_q <= wdata_i[MODE_TAP_LSB +: TAP_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      en_q  <= 1'b0;
    end else if (icr_wr) begin
      lvl_q <= wdata_i[ICR_LVL_LSB +: 2];
      en_q  <= wdata_i[ICR_EN_BIT];
    end
  end

  // hardware set wins over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (icr_wr) flag_q <= wdata_i[ICR_FLAG_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == MODE_ADDR) begin
      rdata_o[MODE_SRC_BIT]          = src_q;
      rdata_o[MODE_TAP_LSB +: TAP_W] = tap_q;
    end else if (addr_i == ICR_ADDR) begin
      rdata_o[ICR_LVL_LSB +: 2] = lvl_q;
      rdata_o[ICR_EN_BIT]       = en_q;
      rdata_o[ICR_FLAG_BIT]     = flag_q;
    end
  end

  assign src_o  = src_q;
  assign tap_o  = tap_q;
  assign flag_o = flag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/tbt_top.sv
module tbt_top
  import tbt_pkg::*;
#(
  parameter int                CNT_W     = 16,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h3F6A,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'h3F6B,
  parameter logic [ADDR_W-1:0] ICR_ADDR  = 16'h3FF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              slow_en_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic             src_sel, clr_wr, req_flag, int_en, tap_rise, adv;
  logic [TAP_W-1:0] tap_code;
  logic [CNT_W-1:0] cnt;

  assign adv = src_sel ? slow_en_i : 1'b1;

  tbt_regs #(
    .ADDR_W   (ADDR_W),
    .MODE_ADDR(MODE_ADDR),
    .CLR_ADDR (CLR_ADDR),
    .ICR_ADDR (ICR_ADDR)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .set_i  (tap_rise),
    .rdata_o(rdata_o),
    .src_o  (src_sel),
    .tap_o  (tap_code),
    .clr_o  (clr_wr),
    .flag_o (req_flag),
    .en_o   (int_en)
  );

  tbt_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .clr_i (clr_wr),
    .tap_i (tap_code),
    .cnt_o (cnt),
    .rise_o(tap_rise)
  );

  assign irq_o = req_flag & int_en;
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker
  import tbt_pkg::*;
#(
  parameter int                CNT_W    = 16,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 16'h3F6B,
  parameter logic [ADDR_W-1:0] ICR_ADDR = 16'h3FF0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wdata0_i,
  input logic              slow_en_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              src_i,
  input logic [TAP_W-1:0]  tap_i,
  input logic              rise_i,
  input logic              flag_i
);
  logic             clr_wr, icr_wr;
  logic             prev_ok, prev_flag, prev_icr_wr;
  logic [CNT_W-1:0] prev_cnt;
  logic [TAP_W-1:0] prev_tap;
  int               pb;

  assign clr_wr = wr_en_i && (addr_i == CLR_ADDR);
  assign icr_wr = wr_en_i && (addr_i == ICR_ADDR);
  assign pb     = tap_bit(prev_tap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ok     <= 1'b0;
      prev_flag   <= 1'b0;
      prev_icr_wr <= 1'b0;
      prev_cnt    <= '0;
      prev_tap    <= '0;
    end else begin
      prev_ok     <= 1'b1;
      prev_flag   <= flag_i;
      prev_icr_wr <= icr_wr;
      prev_cnt    <= cnt_i;
      prev_tap    <= tap_i;
    end
  end

  // R4
  a_r4_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (cnt_i == '0));

  // R5: counter holds or steps by one
  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> (cnt_i == $past(cnt_i) || cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  a_r5_slow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i && !slow_en_i && !clr_wr) |=> $stable(cnt_i));

  // R3: a hardware set coincides with the tapped bit rising
  a_r3_rise_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_ok && flag_i && !prev_flag && !prev_icr_wr) |-> (!prev_cnt[pb] && cnt_i[pb]));

  a_r7_hw_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && icr_wr && !wdata0_i) |=> flag_i);
endmodule

bind tbt_top tbt_checker #(
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W),
  .CLR_ADDR(CLR_ADDR),
  .ICR_ADDR(ICR_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata0_i (wdata_i[0]),
  .slow_en_i(slow_en_i),
  .cnt_i    (cnt),
  .src_i    (src_sel),
  .tap_i    (tap_code),
  .rise_i   (tap_rise),
  .flag_i   (req_flag)
);

// File: tb/tbt_top_test.sv
module tbt_top_test;
  localparam logic [15:0] A_MODE = 16'h3F6A;
  localparam logic [15:0] A_CLR  = 16'h3F6B;
  localparam logic [15:0] A_ICR  = 16'h3FF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = A_ICR;
  logic [7:0]  wdata = 8'h00;
  logic        slow_en = 1'b0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tbt_top uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .slow_en_i(slow_en),
    .rdata_o  (rdata),
    .irq_o    (irq)
  );

  function automatic int div_log(input int code);
    case (code)
      0: return 7;
      1: return 8;
      2: return 9;
      3: return 10;
      4: return 13;
      5: return 14;
      6: return 15;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    addr  = A_ICR;
    wdata = 8'h00;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = A_ICR;
    #1;
  endtask

  // count edges after the clear until the flag shows; returns count
  task automatic wait_flag(inout int n, input int limit);
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (rdata[0]) break;
    end
  endtask

  task automatic sweep(input int code, input bit full);
    int n = 0;
    int nb = div_log(code);
    int first = 1 << (nb - 1);
    wr(A_MODE, 8'(code << 4));
    wr(A_ICR, 8'h02);
    wr(A_CLR, 8'(8'hA5 ^ code));
    wait_flag(n, first + 4);
    check($sformatf("R3 first set code %0d", code), n, first);
    check("R8 irq with flag and enable", int'(irq), 1);
    if (full) begin
      wr(A_ICR, 8'h02);
      n++;
      check("R6 software clear of flag", int'(rdata[0]), 0);
      wait_flag(n, first + (1 << nb) + 4);
      check($sformatf("R3 period code %0d", code), n, first + (1 << nb));
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int n;
    int ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MODE, d); check("R1 mode after reset", d, 0);
    rd(A_CLR, d);  check("R1 clear after reset", d, 0);
    rd(A_ICR, d);  check("R1 control after reset", d, 0);
    check("R1 irq after reset", int'(irq), 0);

    // R2 mode fields; src=1 halts the counter while slow_en is 0
    wr(A_MODE, 8'hFF);
    rd(A_MODE, d); check("R2 mode readback 0xFF", d, 8'h71);
    wr(A_MODE, 8'h8D);
    rd(A_MODE, d); check("R2 mode readback 0x8D", d, 8'h01);
    rd(A_CLR, d);  check("R4 clear reads zero", d, 0);

    // R6 / R8 control register and irq gating
    wr(A_ICR, 8'hFF);
    rd(A_ICR, d); check("R6 control readback", d, 8'hC3);
    check("R8 irq flag=1 en=1", int'(irq), 1);
    rd(16'h1234, d); check("R9 unmapped reads zero", d, 0);
    rd(16'h3F6C, d); check("R9 neighbour address reads zero", d, 0);
    wr(A_ICR, 8'hC1);
    check("R8 irq flag=1 en=0", int'(irq), 0);
    rd(A_ICR, d); check("R6 control readback 0xC1", d, 8'hC1);
    wr(A_ICR, 8'h03);
    check("R8 irq with level 0", int'(irq), 1);
    wr(A_ICR, 8'h02);
    check("R6 write 0 clears flag", int'(rdata[0]), 0);
    check("R8 irq flag=0 en=1", int'(irq), 0);

    // R3 tap sweep
    for (int c = 0; c < 8; c++) sweep(c, c < 5);

    // R4 mid-count clear restarts the count, data ignored
    wr(A_MODE, 8'h00);
    wr(A_ICR, 8'h02);
    wr(A_CLR, 8'h00);
    repeat (40) @(negedge clk);
    check("R4 no flag before clear", int'(rdata[0]), 0);
    wr(A_CLR, 8'hFF);
    n = 0;
    wait_flag(n, 70);
    check("R4 set 64 after second clear", n, 64);

    // R7 hardware set collides with software clear
    wr(A_ICR, 8'h02);
    wr(A_CLR, 8'h3C);
    repeat (63) @(negedge clk);
    check("R7 flag still 0 at edge 63", int'(rdata[0]), 0);
    wr(A_ICR, 8'h02);
    check("R7 hardware set wins", int'(rdata[0]), 1);

    // R5 slow source
    wr(A_MODE, 8'h01);
    wr(A_ICR, 8'h02);
    wr(A_CLR, 8'h00);
    repeat (200) @(negedge clk);
    check("R5 slow source holds without enable", int'(rdata[0]), 0);
    ticks = 0;
    n = 0;
    while (!rdata[0] && n < 1000) begin
      slow_en = (n % 3 == 0);
      if (slow_en) ticks++;
      n++;
      @(negedge clk);
    end
    slow_en = 1'b0;
    check("R5 slow source advances per enable", ticks, 64);
    check("R5 slow source cycle count", n, 3 * 63 + 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule